// File: doc/BRIEF.md
# Neighbour-Coupled SIMD Linear Processor Array

This block is a one-dimensional row of small 8-bit processing elements. Each element sits between two small register banks, and each bank is shared by the two elements beside it. An external sequencer broadcasts one instruction per cycle to every element at once, and the elements hold no program. The instruction gives a direction, a source register index, a destination register index and an ALU operation.

In a cycle with a valid instruction, each element reads the named source register from the bank on the upstream side and the named destination register from the bank on the downstream side. It combines the two values and writes the result into that downstream register at the clock edge. Data therefore travels one bank along the row per instruction as a side effect of the computation. The direction bit decides whether it travels east or west. Register access is random, not first-in-first-out.

The two end banks also have host write and read ports. The host feeds operands in at one end and collects results at the other.

Top module: `simd_line_array`

## Requirements
- R1: After reset every register of every bank reads zero, and both host read ports return zero.
- R2: A host write to the west (or east) end bank stores the data in the named register at the next clock edge. The west (or east) read port shows the current contents of the register selected by its read index, combinationally.
- R3: With `instr_dir` = 0 (eastward), element k (banks numbered 0 at the west end to NUM_PE at the east end) reads source register `instr_src` of bank k and destination register `instr_dst` of bank k+1. It writes the result to register `instr_dst` of bank k+1. All elements do this in the same cycle.
- R4: With `instr_dir` = 1 (westward), element k reads source register `instr_src` of bank k+1 and destination register `instr_dst` of bank k. It writes the result to register `instr_dst` of bank k. All elements do this in the same cycle.
- R5: With A the source value and B the old destination value, `instr_op` encodes: 0 result A; 1 A+B mod 256; 2 A−B mod 256; 3 A AND B; 4 A OR B; 5 A XOR B; 6 unsigned maximum of A and B; 7 no write at all.
- R6: Every element reads values as they stood before the clock edge. A value written by one element in a cycle is not seen by the next element until the following instruction, so data advances exactly one bank per instruction.
- R7: While `instr_valid` is low, no bank register is written by the array, whatever the other instruction fields hold.
- R8: An end bank can be written by the array only in the direction that points at it. When the host and the array write the same register of an end bank in the same cycle, the array's result is stored. Host writes to other registers in that cycle still land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | Broadcast instruction is valid this cycle |
| instr_dir | input | 1 | 0 = results move east, 1 = results move west |
| instr_src | input | 2 | Source register index |
| instr_dst | input | 2 | Destination register index (also second operand) |
| instr_op | input | 3 | ALU operation code |
| west_we | input | 1 | Host write enable, west end bank |
| west_widx | input | 2 | Host write register index, west end bank |
| west_wdata | input | 8 | Host write data, west end bank |
| west_ridx | input | 2 | Host read register index, west end bank |
| west_rdata | output | 8 | Host read data, west end bank |
| east_we | input | 1 | Host write enable, east end bank |
| east_widx | input | 2 | Host write register index, east end bank |
| east_wdata | input | 8 | Host write data, east end bank |
| east_ridx | input | 2 | Host read register index, east end bank |
| east_rdata | output | 8 | Host read data, east end bank |

## Verification
The assertions check several properties on every cycle:
- an array write lands in the named bank register on the next edge;
- an unwritten bank holds its state;
- a host write lands unless the array writes the same register;
- at most one neighbour writes an inner bank;
- pass and maximum results relate correctly to the operands the element selected.

Other behaviours only the bench scenarios can show, because they need many cycles and observation through the end ports:
- operands come from the correct side for each direction;
- every operation encoding is right;
- values advance exactly one bank per instruction;
- invalid instructions leave the inner banks untouched.

The bench shows this by sweeping every operation, direction and register pair against a computed model and then draining the inner banks to the east port.

// File: rtl/simd_line_pkg.sv
package simd_line_pkg;

  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_MAX  = 3'd6,
    OP_NOP  = 3'd7
  } alu_op_e;

endpackage

// File: rtl/simd_alu.sv
module simd_alu
  import simd_line_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res
);

  always_comb begin
    unique case (op)
      OP_PASS: res = a;
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_MAX:  res = (a > b) ? a : b;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/simd_bank.sv
module simd_bank #(
  parameter int unsigned W    = 8,
  parameter int unsigned NREG = 4,
  parameter int unsigned IW   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pe_we,
  input  logic [IW-1:0]             pe_idx,
  input  logic [W-1:0]              pe_data,
  input  logic                      host_we,
  input  logic [IW-1:0]             host_idx,
  input  logic [W-1:0]              host_data,
  output logic [NREG-1:0][W-1:0]    regs_o
);

  logic [NREG-1:0][W-1:0] regs_q;
  logic [NREG-1:0][W-1:0] regs_d;
  logic [NREG-1:0]        reg_en;

  // next state: host first, array result overrides on the same register
  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      regs_d[r] = regs_q[r];
      reg_en[r] = 1'b0;
      if (host_we && (host_idx == IW'(r))) begin
        regs_d[r] = host_data;
        reg_en[r] = 1'b1;
      end
      if (pe_we && (pe_idx == IW'(r))) begin
        regs_d[r] = pe_data;
        reg_en[r] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (reg_en[r]) regs_q[r] <= regs_d[r];
      end
    end
  end

  assign regs_o = regs_q;

  // R3
  pe_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_we |=> regs_q[$past(pe_idx)] == $past(pe_data));

  // R7
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pe_we && !host_we) |=> $stable(regs_q));

  // R2
  host_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !(pe_we && (pe_idx == host_idx)))
      |=> regs_q[$past(host_idx)] == $past(host_data));

endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_line_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter int unsigned NREG = 4,
  parameter int unsigned IW   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    valid,
  input  logic                    dir,
  input  logic [IW-1:0]           src,
  input  logic [IW-1:0]           dst,
  input  alu_op_e                 op,
  input  logic [NREG-1:0][W-1:0]  west_regs,
  input  logic [NREG-1:0][W-1:0]  east_regs,
  output logic                    west_we,
  output logic [IW-1:0]           west_idx,
  output logic [W-1:0]            west_data,
  output logic                    east_we,
  output logic [IW-1:0]           east_idx,
  output logic [W-1:0]            east_data
);

  logic [W-1:0] opnd_a;
  logic [W-1:0] opnd_b;
  logic [W-1:0] alu_res;
  logic         do_write;

  // source from upstream bank, accumulator from downstream bank
  always_comb begin
    if (dir) begin
      opnd_a = east_regs[src];
      opnd_b = west_regs[dst];
    end else begin
      opnd_a = west_regs[src];
      opnd_b = east_regs[dst];
    end
  end

  simd_alu #(.W(W)) i_alu (
    .op  (op),
    .a   (opnd_a),
    .b   (opnd_b),
    .res (alu_res)
  );

  assign do_write  = valid && (op != OP_NOP);
  assign west_we   = do_write && dir;
  assign east_we   = do_write && !dir;
  assign west_idx  = dst;
  assign east_idx  = dst;
  assign west_data = alu_res;
  assign east_data = alu_res;

  // R5
  max_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op == OP_MAX) |-> (alu_res >= opnd_a && alu_res >= opnd_b));

  // R5
  pass_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op == OP_PASS) |-> ((dir ? west_data : east_data) == opnd_a));

endmodule

// File: rtl/simd_line_array.sv
module simd_line_array
  import simd_line_pkg::*;
#(
  parameter int unsigned NUM_PE  = 4,
  parameter int unsigned NUM_REG = 4,
  parameter int unsigned W       = 8,
  localparam int unsigned IW     = $clog2(NUM_REG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic          instr_dir,
  input  logic [IW-1:0] instr_src,
  input  logic [IW-1:0] instr_dst,
  input  logic [2:0]    instr_op,
  input  logic          west_we,
  input  logic [IW-1:0] west_widx,
  input  logic [W-1:0]  west_wdata,
  input  logic [IW-1:0] west_ridx,
  output logic [W-1:0]  west_rdata,
  input  logic          east_we,
  input  logic [IW-1:0] east_widx,
  input  logic [W-1:0]  east_wdata,
  input  logic [IW-1:0] east_ridx,
  output logic [W-1:0]  east_rdata
);

  localparam int unsigned NUM_BANK = NUM_PE + 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta;
  logic rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_n_int <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_n_int <= rst_meta;
    end
  end

  alu_op_e op_e;
  assign op_e = alu_op_e'(instr_op);

  logic [NUM_REG-1:0][W-1:0] bank_regs     [0:NUM_PE];
  logic                      bank_pe_we    [0:NUM_PE];
  logic [IW-1:0]             bank_pe_idx   [0:NUM_PE];
  logic [W-1:0]              bank_pe_data  [0:NUM_PE];
  logic                      bank_host_we  [0:NUM_PE];
  logic [IW-1:0]             bank_host_idx [0:NUM_PE];
  logic [W-1:0]              bank_host_data[0:NUM_PE];

  logic          pe_west_we  [0:NUM_PE-1];
  logic [IW-1:0] pe_west_idx [0:NUM_PE-1];
  logic [W-1:0]  pe_west_data[0:NUM_PE-1];
  logic          pe_east_we  [0:NUM_PE-1];
  logic [IW-1:0] pe_east_idx [0:NUM_PE-1];
  logic [W-1:0]  pe_east_data[0:NUM_PE-1];

  for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
    simd_pe #(.W(W), .NREG(NUM_REG), .IW(IW)) i_pe (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .valid     (instr_valid),
      .dir       (instr_dir),
      .src       (instr_src),
      .dst       (instr_dst),
      .op        (op_e),
      .west_regs (bank_regs[p]),
      .east_regs (bank_regs[p+1]),
      .west_we   (pe_west_we[p]),
      .west_idx  (pe_west_idx[p]),
      .west_data (pe_west_data[p]),
      .east_we   (pe_east_we[p]),
      .east_idx  (pe_east_idx[p]),
      .east_data (pe_east_data[p])
    );
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    if (b == 0) begin : g_west_end
      assign bank_pe_we[b]     = pe_west_we[b];
      assign bank_pe_idx[b]    = pe_west_idx[b];
      assign bank_pe_data[b]   = pe_west_data[b];
      assign bank_host_we[b]   = west_we;
      assign bank_host_idx[b]  = west_widx;
      assign bank_host_data[b] = west_wdata;
    end else if (b == NUM_PE) begin : g_east_end
      assign bank_pe_we[b]     = pe_east_we[b-1];
      assign bank_pe_idx[b]    = pe_east_idx[b-1];
      assign bank_pe_data[b]   = pe_east_data[b-1];
      assign bank_host_we[b]   = east_we;
      assign bank_host_idx[b]  = east_widx;
      assign bank_host_data[b] = east_wdata;
    end else begin : g_inner
      assign bank_pe_we[b]     = pe_east_we[b-1] | pe_west_we[b];
      assign bank_pe_idx[b]    = pe_west_we[b] ? pe_west_idx[b]  : pe_east_idx[b-1];
      assign bank_pe_data[b]   = pe_west_we[b] ? pe_west_data[b] : pe_east_data[b-1];
      assign bank_host_we[b]   = 1'b0;
      assign bank_host_idx[b]  = '0;
      assign bank_host_data[b] = '0;

      // R8
      single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
        $onehot0({pe_east_we[b-1], pe_west_we[b]}));
    end

    simd_bank #(.W(W), .NREG(NUM_REG), .IW(IW)) i_bank (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .pe_we     (bank_pe_we[b]),
      .pe_idx    (bank_pe_idx[b]),
      .pe_data   (bank_pe_data[b]),
      .host_we   (bank_host_we[b]),
      .host_idx  (bank_host_idx[b]),
      .host_data (bank_host_data[b]),
      .regs_o    (bank_regs[b])
    );
  end

  assign west_rdata = bank_regs[0][west_ridx];
  assign east_rdata = bank_regs[NUM_PE][east_ridx];

  // R8
  west_end_dir_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (instr_valid && !instr_dir) |-> !bank_pe_we[0]);

  // R8
  east_end_dir_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (instr_valid && instr_dir) |-> !bank_pe_we[NUM_PE]);

endmodule

// File: tb/test_simd_line_array.sv
module test_simd_line_array;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NR = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       instr_valid, instr_dir;
  logic [1:0] instr_src, instr_dst;
  logic [2:0] instr_op;
  logic       west_we, east_we;
  logic [1:0] west_widx, west_ridx, east_widx, east_ridx;
  logic [7:0] west_wdata, east_wdata, west_rdata, east_rdata;

  int checks = 0;
  int fails  = 0;
  logic [15:0] lf = 16'hACE1;
  logic [7:0] mdl [0:NP][0:NR-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_line_array i_simd_line_array (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_dir(instr_dir),
    .instr_src(instr_src), .instr_dst(instr_dst), .instr_op(instr_op),
    .west_we(west_we), .west_widx(west_widx), .west_wdata(west_wdata),
    .west_ridx(west_ridx), .west_rdata(west_rdata),
    .east_we(east_we), .east_widx(east_widx), .east_wdata(east_wdata),
    .east_ridx(east_ridx), .east_rdata(east_rdata)
  );

  function automatic logic [7:0] rnd();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[7:0] ^ lf[15:8];
  endfunction

  function automatic logic [7:0] alu_f(input int op, input logic [7:0] a, input logic [7:0] b);
    case (op)
      0: return a;
      1: return a + b;
      2: return a - b;
      3: return a & b;
      4: return a | b;
      5: return a ^ b;
      6: return (a > b) ? a : b;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic check_ends(input string tag);
    for (int r = 0; r < NR; r++) begin
      west_ridx = 2'(r);
      east_ridx = 2'(r);
      #1;
      chk(tag, west_rdata, mdl[0][r]);
      chk(tag, east_rdata, mdl[NP][r]);
    end
  endtask

  // one clock of stimulus; model updated from pre-edge state
  task automatic cycle(input logic v, input logic d, input int s, input int t, input int op,
                       input logic wwe, input int wi, input logic [7:0] wd,
                       input logic ewe, input int ei, input logic [7:0] ed);
    logic [7:0] old [0:NP][0:NR-1];
    @(negedge clk);
    instr_valid = v; instr_dir = d;
    instr_src = 2'(s); instr_dst = 2'(t); instr_op = 3'(op);
    west_we = wwe; west_widx = 2'(wi); west_wdata = wd;
    east_we = ewe; east_widx = 2'(ei); east_wdata = ed;
    old = mdl;
    if (wwe) mdl[0][wi] = wd;
    if (ewe) mdl[NP][ei] = ed;
    if (v && op != 7) begin
      for (int p = 0; p < NP; p++) begin
        if (!d) mdl[p+1][t] = alu_f(op, old[p][s], old[p+1][t]);
        else    mdl[p][t]   = alu_f(op, old[p+1][s], old[p][t]);
      end
    end
    @(negedge clk);
    instr_valid = 1'b0; west_we = 1'b0; east_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    string tag;
    rst_n = 1'b0;
    instr_valid = 0; instr_dir = 0; instr_src = 0; instr_dst = 0; instr_op = 0;
    west_we = 0; west_widx = 0; west_wdata = 0; west_ridx = 0;
    east_we = 0; east_widx = 0; east_wdata = 0; east_ridx = 0;
    for (int b = 0; b <= NP; b++) for (int r = 0; r < NR; r++) mdl[b][r] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_ends("R1 reset");

    // R2: host writes at both ends, every register
    for (int r = 0; r < NR; r++) begin
      cycle(0, 0, 0, 0, 0, 1, r, rnd(), 1, NR-1-r, rnd());
      check_ends("R2 host write");
    end

    // R3 R4 R5: every op, direction and register pair
    for (int op = 0; op < 8; op++)
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < NR; s++)
          for (int t = 0; t < NR; t++) begin
            cycle(0, 0, 0, 0, 0, 1, int'(rnd() % 4), rnd(), 1, int'(rnd() % 4), rnd());
            cycle(1, d[0], s, t, op, 0, 0, 0, 0, 0, 0);
            tag = d ? "R4 westward R5 op" : "R3 eastward R5 op";
            check_ends($sformatf("%s %0d", tag, op));
          end

    // R7: invalid instructions with live fields
    for (int k = 0; k < 16; k++) begin
      cycle(0, k[0], k % 4, (k / 4) % 4, k % 7, 0, 0, 0, 0, 0, 0);
      check_ends("R7 invalid");
    end

    // R8: same-register collision on the west end, array wins
    cycle(1, 1, 2, 3, 1, 1, 3, 8'hEE, 1, 3, 8'h5C);
    check_ends("R8 collision");
    // R8: different registers, both land
    cycle(1, 1, 1, 2, 5, 1, 0, 8'h3D, 0, 0, 0);
    check_ends("R8 split write");
    // R8: eastward instruction leaves west end to the host only
    cycle(1, 0, 0, 0, 1, 1, 1, 8'h77, 0, 0, 0);
    check_ends("R8 west end host only");

    // R6: drain inner banks east one step per instruction
    for (int r = 0; r < NR; r++)
      for (int k = 0; k < NP; k++) begin
        cycle(1, 0, r, r, 0, 0, 0, 0, 0, 0, 0);
        check_ends("R6 one bank per step");
      end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule